// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches one port pin and turns its activity into an interrupt request for the CPU. A two-bit sense field chooses what counts as an event: a low level, any change, a falling edge or a rising edge. Each event sets a flag bit. A mask bit gates that flag onto the request line. The CPU's interrupt entry logic pulses an acknowledge input when it takes the interrupt. The block also drives a constant vector number, which the CPU uses to pick the handler.

Software reaches three byte-wide registers through a simple bus. Writes take effect on the clock edge. Read data is registered, so it appears one cycle after the address is presented. Edge detection compares the pin with its level on the previous clock.

In low-level mode the flag behaves differently. It follows the pin, so it is set while the pin is low and clears on the clock after the pin returns high. Neither a software write nor an acknowledge can clear it in this mode.

Top module: `extint_sense`

## Requirements
- R1: After a synchronous reset, the flag, mask and sense registers all read zero and `irq_req` is low.
- R2: The flag is bit 0 at address 0x3C, the mask is bit 0 at address 0x3D, and the sense field is bits 1:0 at address 0x69. Unused bits read as zero. Read data appears on `bus_rdata` one clock after the address.
- R3: With sense 2'b11, a rising pin edge sets the flag and a falling edge does not.
- R4: With sense 2'b10, a falling pin edge sets the flag and a rising edge does not.
- R5: With sense 2'b01, every change of pin level sets the flag.
- R6: With sense other than 2'b00, writing 1 to bit 0 at 0x3C clears the flag, and writing 0 there leaves it unchanged.
- R7: With sense other than 2'b00, an `irq_ack` pulse clears the flag.
- R8: With sense 2'b00, the flag is set on the clock after the pin is sampled low and clears on the clock after the pin is sampled high. Writes of 1 to the flag and `irq_ack` pulses leave it set while the pin stays low.
- R9: `irq_req` is high exactly when both the flag and the mask are set. A set flag with a clear mask raises no request.
- R10: `irq_vector` is constant at the parameter value, which defaults to 2.
- R11: If a detected edge coincides with a clearing write or an acknowledge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 1 | Pin level, already synchronised |
| bus_addr | input | ADDR_W | Register address for both read and write |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data for the previous cycle's address |
| irq_ack | input | 1 | One-cycle pulse when the CPU enters this interrupt |
| irq_req | output | 1 | Interrupt request, equal to flag AND mask |
| irq_vector | output | VEC_W | Fixed vector number |

## Verification
The assertions assume two things about the inputs.
- `pin_in` is already synchronous to `clk`.
- `irq_ack` is only asserted as a single-cycle pulse.

They judge each flag update from the sense value and pin history registered in the cycle before.

The stimulus follows the same rules. It changes the pin, the bus signals and the acknowledge only on falling clock edges, and it keeps every input static while a register read is in flight. Each sampled value therefore belongs to one known state.

// File: rtl/extint_pkg.sv
package extint_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

endpackage

// File: rtl/extint_pin_watch.sv
module extint_pin_watch (
  input  logic clk,
  input  logic rst,
  input  logic pin_in,
  output logic pin_prev_q,
  output logic rise,
  output logic fall
);

  // Load the live pin during reset so that the first cycle sees no edge.
  always_ff @(posedge clk) begin
    if (rst) pin_prev_q <= pin_in;
    else     pin_prev_q <= pin_in;
  end

  assign rise = pin_in & ~pin_prev_q;
  assign fall = ~pin_in & pin_prev_q;

endmodule

// File: rtl/extint_ctrl_regs.sv
module extint_ctrl_regs
  import extint_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter int                DATA_W     = 8,
  parameter logic [ADDR_W-1:0] MASK_ADDR  = 8'h3D,
  parameter logic [ADDR_W-1:0] SENSE_ADDR = 8'h69
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output sense_e            sense_q,
  output logic              mask_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      sense_q <= SENSE_LOW;
      mask_q  <= 1'b0;
    end else if (bus_wr) begin
      if (bus_addr == SENSE_ADDR) sense_q <= sense_e'(bus_wdata[1:0]);
      if (bus_addr == MASK_ADDR)  mask_q  <= bus_wdata[0];
    end
  end

  // Only the low two data bits are stored.
  logic unused_wdata_hi;
  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:2];

endmodule

// File: rtl/extint_flag.sv
module extint_flag
  import extint_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  sense_e sense,
  input  logic   pin_in,
  input  logic   rise,
  input  logic   fall,
  input  logic   sw_clear,
  input  logic   ack,
  output logic   flag_q
);

  logic event_hit;
  logic flag_d;

  always_comb begin
    unique case (sense)
      SENSE_RISE: event_hit = rise;
      SENSE_FALL: event_hit = fall;
      SENSE_ANY:  event_hit = rise | fall;
      default:    event_hit = 1'b0;
    endcase

    if (sense == SENSE_LOW)
      flag_d = ~pin_in;                                   // sticky: tracks the pin only
    else
      flag_d = event_hit | (flag_q & ~(sw_clear | ack));  // a new event beats a clear
  end

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else     flag_q <= flag_d;
  end

endmodule

// File: rtl/extint_sense.sv
module extint_sense
  import extint_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter int                DATA_W     = 8,
  parameter int                VEC_W      = 8,
  parameter logic [ADDR_W-1:0] FLAG_ADDR  = 8'h3C,
  parameter logic [ADDR_W-1:0] MASK_ADDR  = 8'h3D,
  parameter logic [ADDR_W-1:0] SENSE_ADDR = 8'h69,
  parameter logic [VEC_W-1:0]  VECTOR     = 8'd2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pin_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              irq_ack,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vector
);

  localparam int PAD_W = DATA_W - 1;

  logic   pin_prev_q;
  logic   rise;
  logic   fall;
  sense_e sense_q;
  logic   mask_q;
  logic   flag_q;
  logic   flag_wr_clear;

  extint_pin_watch u_watch (
    .clk        (clk),
    .rst        (rst),
    .pin_in     (pin_in),
    .pin_prev_q (pin_prev_q),
    .rise       (rise),
    .fall       (fall)
  );

  extint_ctrl_regs #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .MASK_ADDR  (MASK_ADDR),
    .SENSE_ADDR (SENSE_ADDR)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .sense_q   (sense_q),
    .mask_q    (mask_q)
  );

  assign flag_wr_clear = bus_wr & (bus_addr == FLAG_ADDR) & bus_wdata[0];

  extint_flag u_flag (
    .clk      (clk),
    .rst      (rst),
    .sense    (sense_q),
    .pin_in   (pin_in),
    .rise     (rise),
    .fall     (fall),
    .sw_clear (flag_wr_clear),
    .ack      (irq_ack),
    .flag_q   (flag_q)
  );

  // Registered read port.
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      unique case (bus_addr)
        FLAG_ADDR:  bus_rdata <= {{PAD_W{1'b0}}, flag_q};
        MASK_ADDR:  bus_rdata <= {{PAD_W{1'b0}}, mask_q};
        SENSE_ADDR: bus_rdata <= {{(DATA_W-2){1'b0}}, sense_q};
        default:    bus_rdata <= '0;
      endcase
    end
  end

  assign irq_req    = flag_q & mask_q;
  assign irq_vector = VECTOR;

endmodule

// File: rtl/extint_sense_chk.sv
module extint_sense_chk #(
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 8,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 8'h3C
) (
  input logic              clk,
  input logic              rst,
  input logic              pin_in,
  input logic              pin_prev_q,
  input logic [1:0]        sense_q,
  input logic              flag_q,
  input logic              mask_q,
  input logic              irq_req,
  input logic              irq_ack,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata
);

  // R8: in low-level mode the flag mirrors the pin sampled on the previous clock
  a_r8_level_follows: assert property (@(posedge clk) disable iff (rst)
    (sense_q == 2'b00) |=> (flag_q == !$past(pin_in)));

  // R3: a falling edge in rising mode leaves a clear flag clear
  a_r3_fall_ignored: assert property (@(posedge clk) disable iff (rst)
    (sense_q == 2'b11 && pin_prev_q && !pin_in && !flag_q) |=> !flag_q);

  // R6: a write of 1 clears the flag in edge modes when no edge is present
  a_r6_write_clears: assert property (@(posedge clk) disable iff (rst)
    (sense_q != 2'b00 && pin_in == pin_prev_q && bus_wr &&
     bus_addr == FLAG_ADDR && bus_wdata[0]) |=> !flag_q);

  // R7: the acknowledge clears the flag in edge modes
  a_r7_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (sense_q != 2'b00 && pin_in == pin_prev_q && irq_ack) |=> !flag_q);

  // R5 / R11: any change in any-change mode sets the flag, whatever clear arrives with it
  a_r11_event_wins: assert property (@(posedge clk) disable iff (rst)
    (sense_q == 2'b01 && pin_in != pin_prev_q) |=> flag_q);

  // R9: no request while the mask is clear
  a_r9_mask_gates: assert property (@(posedge clk) disable iff (rst)
    !mask_q |-> !irq_req);

endmodule

bind extint_sense extint_sense_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .FLAG_ADDR (FLAG_ADDR)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pin_in     (pin_in),
  .pin_prev_q (pin_prev_q),
  .sense_q    (sense_q),
  .flag_q     (flag_q),
  .mask_q     (mask_q),
  .irq_req    (irq_req),
  .irq_ack    (irq_ack),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata)
);

// File: tb/sim_extint_sense.sv
`timescale 1ns/1ps
module sim_extint_sense;

  localparam logic [7:0] A_FLAG  = 8'h3C;
  localparam logic [7:0] A_MASK  = 8'h3D;
  localparam logic [7:0] A_SENSE = 8'h69;

  logic       clk = 1'b0;
  logic       rst;
  logic       pin_in;
  logic [7:0] bus_addr;
  logic       bus_wr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       irq_ack;
  logic       irq_req;
  logic [7:0] irq_vector;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  logic [7:0] exp_d[$];
  logic       exp_r[$];
  string      exp_t[$];
  logic       rd_valid = 1'b0;
  logic       rd_stage = 1'b0;

  always #5 clk = ~clk;

  extint_sense u0 (
    .clk        (clk),
    .rst        (rst),
    .pin_in     (pin_in),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .irq_ack    (irq_ack),
    .irq_req    (irq_req),
    .irq_vector (irq_vector)
  );

  // Monitor: a read issued before a rising edge is compared at the next falling edge.
  always @(posedge clk) rd_stage <= rd_valid;

  always @(negedge clk) begin
    if (rd_stage && exp_d.size() > 0) begin
      logic [7:0] ed;
      logic       er;
      string      tg;
      ed = exp_d.pop_front();
      er = exp_r.pop_front();
      tg = exp_t.pop_front();
      vectors++;
      if (bus_rdata !== ed || irq_req !== er) begin
        fails++;
        $display("FAIL %s: rdata=%h req=%b expected rdata=%h req=%b",
                 tg, bus_rdata, irq_req, ed, er);
      end
    end
  end

  // Driver tasks: each one starts and ends on a falling edge.
  task automatic probe(input logic [7:0] a, input logic [7:0] ed,
                       input logic er, input string tg);
    bus_addr = a;
    exp_d.push_back(ed);
    exp_r.push_back(er);
    exp_t.push_back(tg);
    rd_valid = 1'b1;
    @(negedge clk);
    rd_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic set_pin(input logic v);
    pin_in = v;
    @(negedge clk);
  endtask

  task automatic ack_pulse();
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog: done=%0b expected 1", done);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; pin_in = 1'b1; bus_addr = '0; bus_wr = 1'b0;
    bus_wdata = '0; irq_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    probe(A_FLAG,  8'h00, 1'b0, "R1");
    probe(A_MASK,  8'h00, 1'b0, "R1");
    probe(A_SENSE, 8'h00, 1'b0, "R1");

    // R10 fixed vector
    vectors++;
    if (irq_vector !== 8'd2) begin
      fails++;
      $display("FAIL R10: vector=%0d expected 2", irq_vector);
    end

    // R2 register map, high bits dropped
    wr(A_MASK, 8'hFF);
    probe(A_MASK, 8'h01, 1'b0, "R2");
    wr(A_SENSE, 8'hFF);
    probe(A_SENSE, 8'h03, 1'b0, "R2");
    probe(8'h00, 8'h00, 1'b0, "R2");

    // R3 rising mode (pin currently 1)
    set_pin(1'b0);
    probe(A_FLAG, 8'h00, 1'b0, "R3");
    set_pin(1'b1);
    probe(A_FLAG, 8'h01, 1'b1, "R3");

    // R6 write 0 keeps, write 1 clears
    wr(A_FLAG, 8'h00);
    probe(A_FLAG, 8'h01, 1'b1, "R6");
    wr(A_FLAG, 8'h01);
    probe(A_FLAG, 8'h00, 1'b0, "R6");

    // R4 falling mode
    wr(A_SENSE, 8'h02);
    set_pin(1'b0);
    probe(A_FLAG, 8'h01, 1'b1, "R4");
    wr(A_FLAG, 8'h01);
    set_pin(1'b1);
    probe(A_FLAG, 8'h00, 1'b0, "R4");

    // R7 acknowledge clears
    set_pin(1'b0);
    probe(A_FLAG, 8'h01, 1'b1, "R7");
    ack_pulse();
    probe(A_FLAG, 8'h00, 1'b0, "R7");

    // R5 any change
    wr(A_SENSE, 8'h01);
    set_pin(1'b1);
    probe(A_FLAG, 8'h01, 1'b1, "R5");
    wr(A_FLAG, 8'h01);
    set_pin(1'b0);
    probe(A_FLAG, 8'h01, 1'b1, "R5");
    wr(A_FLAG, 8'h01);
    probe(A_FLAG, 8'h00, 1'b0, "R5");

    // R9 mask gating
    wr(A_MASK, 8'h00);
    set_pin(1'b1);
    probe(A_FLAG, 8'h01, 1'b0, "R9");
    wr(A_MASK, 8'h01);
    probe(A_FLAG, 8'h01, 1'b1, "R9");
    wr(A_FLAG, 8'h01);
    probe(A_FLAG, 8'h00, 1'b0, "R9");

    // R11 edge wins over a coincident ack and clearing write
    wr(A_SENSE, 8'h03);
    set_pin(1'b0);
    probe(A_FLAG, 8'h00, 1'b0, "R11");
    pin_in = 1'b1; irq_ack = 1'b1;
    bus_addr = A_FLAG; bus_wdata = 8'h01; bus_wr = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0; bus_wr = 1'b0;
    probe(A_FLAG, 8'h01, 1'b1, "R11");
    ack_pulse();

    // R8 sticky low level
    wr(A_SENSE, 8'h00);
    probe(A_FLAG, 8'h00, 1'b0, "R8");
    set_pin(1'b0);
    probe(A_FLAG, 8'h01, 1'b1, "R8");
    wr(A_FLAG, 8'h01);
    probe(A_FLAG, 8'h01, 1'b1, "R8");
    ack_pulse();
    probe(A_FLAG, 8'h01, 1'b1, "R8");
    set_pin(1'b1);
    probe(A_FLAG, 8'h00, 1'b0, "R8");

    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule